// File: doc/BRIEF.md
# Single-Wire Line Break Detector and Autobaud Synchronizer

This block watches a single-wire, half-duplex serial line that idles high. It recognises a BREAK: a low level held longer than any legal frame. A BREAK resets the link, which is the host's way of restarting a session. After the break is released the block requires a quiet high guard interval. It then times the synchronization character 0x55 to learn the bit period. No clock is shared with the host, so the period is measured in cycles of the local system clock.

The character travels LSB first with a start bit, even parity and two stop bits. It therefore shows five falling edges, eight bit times apart from the first to the last. The block counts the clocks across that span and divides the count by eight. It accepts the result only if it lies inside a configured window and the stop bits are then seen high. When those tests pass, it raises a synchronized flag and presents the period to the byte transceiver. A one-cycle link-reset pulse tells the logic above to drop its state and clear any latched errors. A timeout returns the block to the unsynchronized state when the host stays silent.

Top module: `sline_autobaud`

## Requirements
- R1: The line is resampled through SYNC_STAGES flip-flops. A run of exactly BREAK_CYCLES consecutive low samples qualifies a break; a run of BREAK_CYCLES-1 samples does not.
- R2: A qualified break, in any state, produces a `link_rst_o` pulse exactly one clock wide. In the same cycle, `synced_o` reads 0 and `bit_period_o` reads 0. One long low produces only one pulse.
- R3: After the break is released, the line must stay high for a guard interval. The line is released by driving it high at a falling clock edge N. A sync character whose start bit is driven at edge N+GUARD_CYCLES is abandoned. One driven at edge N+GUARD_CYCLES+1 is measured.
- R4: The sync character is 0x55, sent LSB first: start bit 0, eight data bits, an even parity bit (0), and two stop bits (1). The block measures from its first falling edge to its fifth.
- R5: `bit_period_o` equals the measured span divided by eight, truncated (ROUND=0). While `synced_o` is 0, `bit_period_o` is 0.
- R6: A computed period below MIN_BIT or above MAX_BIT is rejected. The block then waits for a new break, and a later sync character without a break does not synchronize it.
- R7: `synced_o` rises only after the line has stayed high for twice the computed period after the parity bit. A low inside that window rejects the character.
- R8: If no falling edge arrives within SYNC_TIMEOUT clocks after the guard interval, the block returns to the unsynchronized state. The same applies if the five falling edges are not complete within SYNC_TIMEOUT clocks of the first one.
- R9: When the first falling edge arrives in the last cycle of the wait window, the edge wins over the timeout. With release at edge N, a start bit driven at edge N+GUARD_CYCLES+SYNC_TIMEOUT is measured, and one driven a clock later is not.
- R10: While synchronized, line activity shorter than a break leaves `synced_o` and `bit_period_o` unchanged. This includes further frames and lows of BREAK_CYCLES-1 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level of the single-wire line (idle high) |
| bit_period_o | output | CNT_W | Measured bit period in clocks, valid while synchronized |
| link_rst_o | output | 1 | One-cycle pulse when a break qualifies |
| synced_o | output | 1 | Link synchronized to the host's baud rate |

## Verification
The two functions that can act in the same cycle are the expiry of the sync-wait timer and the arrival of the first falling edge of the sync character. The bench releases a break and starts the character exactly GUARD_CYCLES+SYNC_TIMEOUT falling edges later, then repeats the test one clock later. The first case must synchronize and the second must not. Guard expiry against an early start bit is provoked the same way, and so is a break of exactly BREAK_CYCLES samples against one of BREAK_CYCLES-1 samples. Each case is judged both by the end state and by the clock-by-clock reference model.

// File: rtl/sline_ab_pkg.sv
package sline_ab_pkg;

   typedef enum logic [2:0] {
      AB_HUNT  = 3'd0,
      AB_BREAK = 3'd1,
      AB_GUARD = 3'd2,
      AB_WAIT  = 3'd3,
      AB_MEAS  = 3'd4,
      AB_STOP  = 3'd5,
      AB_LOCK  = 3'd6
   } ab_state_e;

   // falling edges in the 0x55 frame and log2 of the bit times they span
   localparam int unsigned SYNC_FALLS = 5;
   localparam int unsigned SPAN_SHIFT = 3;
   localparam int unsigned FRAME_BITS = 12;

endpackage

// File: rtl/sline_ab_sampler.sv
module sline_ab_sampler #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic ln_o,
   output logic fall_o,
   output logic rise_o
);

   logic ln_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sline_ab_sampler: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b1;
            else        s0 <= line_i;
         end
         assign ln_o = s0;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], line_i};
         end
         assign ln_o = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ln_q <= 1'b1;
      else        ln_q <= ln_o;
   end

   assign fall_o = ln_q & ~ln_o;
   assign rise_o = ~ln_q & ln_o;

endmodule

// File: rtl/sline_ab_lowtimer.sv
module sline_ab_lowtimer #(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned BREAK_CYCLES = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ln_i,
   output logic brk_o
);

   localparam logic [CNT_W-1:0] LOW_SAT  = CNT_W'(BREAK_CYCLES);
   localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(BREAK_CYCLES - 1);

   logic [CNT_W-1:0] low_cnt;

   // saturating run length of low samples; the count never wraps, so one
   // long low yields a single qualification
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (ln_i)             low_cnt <= '0;
      else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign brk_o = !ln_i && (low_cnt == LOW_LAST);

endmodule

// File: rtl/sline_ab_meter.sv
module sline_ab_meter
   import sline_ab_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter bit          ROUND = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_i,
   input  logic             fall_i,
   output logic [CNT_W-1:0] span_o,
   output logic             last_o,
   output logic [CNT_W-1:0] period_o
);

   logic [CNT_W-1:0] span_q;
   logic [2:0]       nfall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span_q  <= '0;
         nfall_q <= '0;
      end else if (start_i) begin
         span_q  <= CNT_W'(1);
         nfall_q <= 3'd1;
      end else if (step_i) begin
         span_q <= span_q + 1'b1;
         if (fall_i) nfall_q <= nfall_q + 1'b1;
      end
   end

   assign span_o = span_q;
   assign last_o = step_i && fall_i && (nfall_q == 3'(SYNC_FALLS - 1));

   generate
      if (ROUND) begin : g_round
         logic [CNT_W:0] biased;
         assign biased   = {1'b0, span_q} + (CNT_W+1)'(1 << (SPAN_SHIFT - 1));
         assign period_o = CNT_W'(biased >> SPAN_SHIFT);
      end else begin : g_trunc
         assign period_o = CNT_W'(span_q >> SPAN_SHIFT);
      end
   endgenerate

endmodule

// File: rtl/sline_autobaud.sv
module sline_autobaud
   import sline_ab_pkg::*;
#(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned BREAK_CYCLES = 600,
   parameter int unsigned GUARD_CYCLES = 20,
   parameter int unsigned SYNC_TIMEOUT = 1000,
   parameter int unsigned MIN_BIT      = 4,
   parameter int unsigned MAX_BIT      = 40,
   parameter bit          ROUND        = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   output logic [CNT_W-1:0] bit_period_o,
   output logic             link_rst_o,
   output logic             synced_o
);

   localparam logic [CNT_W-1:0] GRD_LAST = CNT_W'(GUARD_CYCLES - 1);
   localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(SYNC_TIMEOUT - 1);
   localparam logic [CNT_W-1:0] PER_MIN  = CNT_W'(MIN_BIT);
   localparam logic [CNT_W-1:0] PER_MAX  = CNT_W'(MAX_BIT);

   generate
      if (BREAK_CYCLES <= FRAME_BITS * MAX_BIT) begin : g_bad_break
         $error("sline_autobaud: BREAK_CYCLES must exceed a frame at MAX_BIT");
      end
      if (MIN_BIT < 1 || MIN_BIT > MAX_BIT) begin : g_bad_window
         $error("sline_autobaud: need 1 <= MIN_BIT <= MAX_BIT");
      end
      if (SYNC_TIMEOUT <= (1 << SPAN_SHIFT) * MAX_BIT) begin : g_bad_timeout
         $error("sline_autobaud: SYNC_TIMEOUT shorter than a sync span");
      end
      if (BREAK_CYCLES >= (64'd1 << CNT_W) || SYNC_TIMEOUT >= (64'd1 << CNT_W)) begin : g_bad_width
         $error("sline_autobaud: CNT_W too narrow for the counters");
      end
      if (GUARD_CYCLES < 1) begin : g_bad_guard
         $error("sline_autobaud: GUARD_CYCLES must be at least 1");
      end
   endgenerate

   logic ln_s, fall_s, rise_s, brk_s;
   logic [CNT_W-1:0] span_s, period_s;
   logic             last_s;

   ab_state_e        state_q;
   logic [CNT_W-1:0] gcnt_q, tcnt_q, cand_q, per_q;
   logic [CNT_W:0]   hcnt_q;
   logic             hi_seen_q, synced_q, lrst_q;
   logic             meas_start, meas_step, per_ok;
   logic [CNT_W:0]   stop_last;

   sline_ab_sampler #(
      .STAGES (SYNC_STAGES)
   ) u_samp (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_i),
      .ln_o   (ln_s),
      .fall_o (fall_s),
      .rise_o (rise_s)
   );

   sline_ab_lowtimer #(
      .CNT_W        (CNT_W),
      .BREAK_CYCLES (BREAK_CYCLES)
   ) u_low (
      .clk   (clk),
      .rst_n (rst_n),
      .ln_i  (ln_s),
      .brk_o (brk_s)
   );

   assign meas_start = (state_q == AB_WAIT) && fall_s && !brk_s;
   assign meas_step  = (state_q == AB_MEAS);

   sline_ab_meter #(
      .CNT_W (CNT_W),
      .ROUND (ROUND)
   ) u_meas (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (meas_start),
      .step_i   (meas_step),
      .fall_i   (fall_s),
      .span_o   (span_s),
      .last_o   (last_s),
      .period_o (period_s)
   );

   assign per_ok    = (period_s >= PER_MIN) && (period_s <= PER_MAX);
   assign stop_last = {cand_q, 1'b0} - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= AB_HUNT;
         gcnt_q    <= '0;
         tcnt_q    <= '0;
         hcnt_q    <= '0;
         cand_q    <= '0;
         per_q     <= '0;
         hi_seen_q <= 1'b0;
         synced_q  <= 1'b0;
         lrst_q    <= 1'b0;
      end else begin
         lrst_q <= brk_s;
         if (brk_s) begin
            state_q  <= AB_BREAK;
            synced_q <= 1'b0;
            per_q    <= '0;
         end else begin
            unique case (state_q)
               AB_BREAK: begin
                  if (rise_s) begin
                     state_q <= AB_GUARD;
                     gcnt_q  <= '0;
                  end
               end
               AB_GUARD: begin
                  if (!ln_s) begin
                     state_q <= AB_HUNT;
                  end else if (gcnt_q == GRD_LAST) begin
                     state_q <= AB_WAIT;
                     tcnt_q  <= '0;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
               AB_WAIT: begin
                  if (fall_s)                  state_q <= AB_MEAS;
                  else if (tcnt_q == TMO_LAST) state_q <= AB_HUNT;
                  else                         tcnt_q  <= tcnt_q + 1'b1;
               end
               AB_MEAS: begin
                  if (last_s) begin
                     if (per_ok) begin
                        state_q   <= AB_STOP;
                        cand_q    <= period_s;
                        hcnt_q    <= '0;
                        hi_seen_q <= 1'b0;
                     end else begin
                        state_q <= AB_HUNT;
                     end
                  end else if (!fall_s && span_s == TMO_LAST) begin
                     state_q <= AB_HUNT;
                  end
               end
               AB_STOP: begin
                  if (!ln_s) begin
                     if (hi_seen_q) state_q <= AB_HUNT;
                  end else begin
                     hi_seen_q <= 1'b1;
                     if (hcnt_q == stop_last) begin
                        state_q  <= AB_LOCK;
                        synced_q <= 1'b1;
                        per_q    <= cand_q;
                     end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign bit_period_o = per_q;
   assign link_rst_o   = lrst_q;
   assign synced_o     = synced_q;

endmodule

// File: rtl/sline_autobaud_chk.sv
module sline_autobaud_chk #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned MIN_BIT = 4,
   parameter int unsigned MAX_BIT = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ln_s,
   input logic [CNT_W-1:0] bit_period_o,
   input logic             link_rst_o,
   input logic             synced_o
);

   // R2: reset pulse lasts one clock
   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      link_rst_o |=> !link_rst_o);

   // R2: pulse coincides with cleared outputs
   a_r2_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
      link_rst_o |-> (!synced_o && bit_period_o == '0));

   // R1: a break is only ever raised by a low line
   a_r1_break_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      link_rst_o |-> !$past(ln_s));

   // R6: a locked period lies inside the window
   a_r6_period_window: assert property (@(posedge clk) disable iff (!rst_n)
      synced_o |-> (bit_period_o >= CNT_W'(MIN_BIT) && bit_period_o <= CNT_W'(MAX_BIT)));

   // R5: no period is shown while unsynchronized
   a_r5_zero_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
      !synced_o |-> (bit_period_o == '0));

   // R7: lock is taken on a high stop sample
   a_r7_lock_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced_o) |-> $past(ln_s));

   // R10: the period holds while locked
   a_r10_period_held: assert property (@(posedge clk) disable iff (!rst_n)
      (synced_o && $past(synced_o)) |-> $stable(bit_period_o));

endmodule

bind sline_autobaud sline_autobaud_chk #(
   .CNT_W   (CNT_W),
   .MIN_BIT (MIN_BIT),
   .MAX_BIT (MAX_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ln_s         (ln_s),
   .bit_period_o (bit_period_o),
   .link_rst_o   (link_rst_o),
   .synced_o     (synced_o)
);

// File: tb/sim_sline_autobaud.sv
module sim_sline_autobaud;

   localparam int CLK_PERIOD = 10;
   localparam int CW   = 16;
   localparam int STG  = 2;
   localparam int BRK  = 600;
   localparam int GRD  = 20;
   localparam int TMO  = 1000;
   localparam int MINB = 4;
   localparam int MAXB = 40;

   localparam int S_HUNT = 0, S_BRK = 1, S_GRD = 2, S_WAIT = 3,
                  S_MEAS = 4, S_STOP = 5, S_LOCK = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line = 1'b1;
   logic [CW-1:0] bit_period_o;
   logic          link_rst_o;
   logic          synced_o;

   int n_chk = 0;
   int n_fail = 0;
   int lrst_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sline_autobaud #(
      .CNT_W        (CW),
      .SYNC_STAGES  (STG),
      .BREAK_CYCLES (BRK),
      .GUARD_CYCLES (GRD),
      .SYNC_TIMEOUT (TMO),
      .MIN_BIT      (MINB),
      .MAX_BIT      (MAXB),
      .ROUND        (1'b0)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (line),
      .bit_period_o (bit_period_o),
      .link_rst_o   (link_rst_o),
      .synced_o     (synced_o)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [STG-1:0] m_pipe;
   int m_lnq, m_low, m_st, m_g, m_t, m_span, m_nf, m_h, m_hi, m_cand;
   int m_per, m_syn, m_lrst;

   always @(posedge clk) begin : ref_model
      int ln, fl, rs, bk, pc;
      if (!rst_n) begin
         m_pipe = '1; m_lnq = 1; m_low = 0; m_st = S_HUNT;
         m_g = 0; m_t = 0; m_span = 0; m_nf = 0; m_h = 0; m_hi = 0;
         m_cand = 0; m_per = 0; m_syn = 0; m_lrst = 0;
      end else begin
         ln = int'(m_pipe[STG-1]);
         fl = (m_lnq == 1 && ln == 0) ? 1 : 0;
         rs = (m_lnq == 0 && ln == 1) ? 1 : 0;
         bk = (ln == 0 && m_low == BRK - 1) ? 1 : 0;
         m_lrst = bk;
         if (bk != 0) begin
            m_st = S_BRK; m_syn = 0; m_per = 0;
         end else begin
            case (m_st)
               S_BRK: if (rs != 0) begin m_st = S_GRD; m_g = 0; end
               S_GRD: begin
                  if (ln == 0) m_st = S_HUNT;
                  else if (m_g == GRD - 1) begin m_st = S_WAIT; m_t = 0; end
                  else m_g++;
               end
               S_WAIT: begin
                  if (fl != 0) begin m_st = S_MEAS; m_span = 1; m_nf = 1; end
                  else if (m_t == TMO - 1) m_st = S_HUNT;
                  else m_t++;
               end
               S_MEAS: begin
                  if (fl != 0 && m_nf == 4) begin
                     pc = m_span / 8;
                     if (pc >= MINB && pc <= MAXB) begin
                        m_st = S_STOP; m_cand = pc; m_h = 0; m_hi = 0;
                     end else m_st = S_HUNT;
                  end else if (fl != 0) begin
                     m_nf++; m_span++;
                  end else if (m_span == TMO - 1) m_st = S_HUNT;
                  else m_span++;
               end
               S_STOP: begin
                  if (ln == 0) begin
                     if (m_hi != 0) m_st = S_HUNT;
                  end else begin
                     m_hi = 1;
                     if (m_h == 2 * m_cand - 1) begin
                        m_st = S_LOCK; m_syn = 1; m_per = m_cand;
                     end else m_h++;
                  end
               end
               default: ;
            endcase
         end
         if (ln != 0) m_low = 0;
         else if (m_low != BRK) m_low++;
         m_lnq = ln;
         m_pipe = {m_pipe[STG-2:0], line};
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 model synced_o", int'(synced_o), m_syn);
         chk("R5 model bit_period_o", int'(bit_period_o), m_per);
         chk("R2 model link_rst_o", int'(link_rst_o), m_lrst);
         if (link_rst_o) lrst_cnt++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_break(input int len);
      line = 1'b0;
      repeat (len) @(negedge clk);
      line = 1'b1;
   endtask

   task automatic send_sync(input int b, input int first_len, input bit stop2);
      logic [11:0] fr;
      fr[0]    = 1'b0;
      fr[8:1]  = 8'h55;
      fr[9]    = ^8'h55;
      fr[10]   = 1'b1;
      fr[11]   = stop2;
      for (int i = 0; i < 12; i++) begin
         line = fr[i];
         repeat ((i == 0) ? first_len : b) @(negedge clk);
      end
      line = 1'b1;
   endtask

   task automatic break_then_sync(input int gap, input int b);
      do_break(BRK + 50);
      idle(gap);
      send_sync(b, b, 1'b1);
      idle(4 * b + 10);
   endtask

   // ---------------- scenarios ----------------
   initial begin : main
      int c0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R2 reset synced_o", int'(synced_o), 0);
      chk("R5 reset bit_period_o", int'(bit_period_o), 0);
      chk("R2 reset link_rst_o", int'(link_rst_o), 0);

      // R1 R4 R5 R7: ordinary session
      c0 = lrst_cnt;
      break_then_sync(GRD + 10, 10);
      chk("R1 one pulse per long low", lrst_cnt - c0, 1);
      chk("R7 synced after sync", int'(synced_o), 1);
      chk("R4 period from 0x55", int'(bit_period_o), 10);

      // R10 R1: locked, sub-break low and extra frame
      c0 = lrst_cnt;
      do_break(BRK - 1);
      idle(10);
      send_sync(3, 3, 1'b1);
      idle(20);
      chk("R1 short low no pulse", lrst_cnt - c0, 0);
      chk("R10 still synced", int'(synced_o), 1);
      chk("R10 period kept", int'(bit_period_o), 10);

      // R2: break of exactly BRK samples while locked
      c0 = lrst_cnt;
      do_break(BRK);
      idle(5);
      chk("R2 exact break pulse", lrst_cnt - c0, 1);
      chk("R2 synced cleared", int'(synced_o), 0);
      chk("R2 period cleared", int'(bit_period_o), 0);
      idle(GRD + 5);
      send_sync(7, 7, 1'b1);
      idle(40);
      chk("R4 period 7", int'(bit_period_o), 7);

      // R5: truncation, long start bit gives span 85
      do_break(BRK + 50);
      idle(GRD + 5);
      send_sync(10, 15, 1'b1);
      idle(50);
      chk("R5 truncated period", int'(bit_period_o), 10);

      // R6: window edges
      break_then_sync(GRD + 5, 3);
      chk("R6 too fast rejected", int'(synced_o), 0);
      send_sync(10, 10, 1'b1);
      idle(50);
      chk("R6 no lock without new break", int'(synced_o), 0);
      break_then_sync(GRD + 5, MINB);
      chk("R6 MIN_BIT accepted", int'(bit_period_o), MINB);
      break_then_sync(GRD + 5, MAXB);
      chk("R6 MAX_BIT accepted", int'(bit_period_o), MAXB);
      break_then_sync(GRD + 5, MAXB + 1);
      chk("R6 too slow rejected", int'(synced_o), 0);

      // R3: guard boundary
      break_then_sync(GRD, 10);
      chk("R3 start inside guard rejected", int'(synced_o), 0);
      break_then_sync(GRD + 1, 10);
      chk("R3 start after guard accepted", int'(synced_o), 1);

      // R9 R8: edge against wait timeout in the same cycle
      break_then_sync(GRD + TMO, 10);
      chk("R9 edge in last wait cycle wins", int'(synced_o), 1);
      break_then_sync(GRD + TMO + 1, 10);
      chk("R8 wait timeout expired", int'(synced_o), 0);

      // R7: second stop bit low
      do_break(BRK + 50);
      idle(GRD + 5);
      send_sync(10, 10, 1'b0);
      idle(60);
      chk("R7 low stop bit rejected", int'(synced_o), 0);
      chk("R7 period stays 0", int'(bit_period_o), 0);

      // R8: measurement stalls after one falling edge
      do_break(BRK + 50);
      idle(GRD + 5);
      line = 1'b0;
      idle(10);
      line = 1'b1;
      idle(TMO + 20);
      send_sync(10, 10, 1'b1);
      idle(50);
      chk("R8 measurement timeout", int'(synced_o), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule